// File: doc/BRIEF.md
# Thermal Spare Core Manager

This block watches the temperature of every core in a multicore cluster and handles a pool of reserved spare cores. When a working core heats up past a programmable activation level, the block marks it so that the scheduler gives it no new work. It then picks a spare, brings it up and asks for that core's threads to be moved to the spare. Spares wait in one of two grades. A warm spare stays powered with its clock stopped and can take over at once. A dark spare is fully unpowered and produces no heat, but it needs a power-up wait before its clock may run.

The activation level has to lie strictly between the steady-state and the throttling temperatures. The controller handles one hand-over at a time, so separate crises are served one after another. A core that has been drained stays powered with its clock gated. It joins the warm pool once it has cooled below the steady-state level. If no spare is free, the block raises a throttle request for the overheated core. The block does not set scheduling policy or clock frequency.

Top module: `thermal_spare_mgr`

## Requirements
- R1: After reset, cores in the warm-spare mask (default core 2) are powered with the clock off. Cores in the dark-spare mask (default core 3) are unpowered. All other cores are powered and clocked. Every non-working core shows its no-new-work bit, and no hand-over or throttle request is active.
- R2: The effective activation level is the programmed value when it lies strictly between steady-state and throttle. If the programmed value is at or below steady-state, the level is steady-state + 1. If it is at or above throttle, the level is throttle − 1.
- R3: A working core whose temperature is below the effective level keeps its no-new-work bit low. A working core at or above the level has the bit high from the next cycle onward.
- R4: A crisis on a working core with a warm spare free starts a hand-over on the next clock edge. The lowest-numbered warm spare is chosen. Its clock turns on, and the one-hot source and destination outputs name the hot core and the spare.
- R5: When no warm spare is free, the lowest-numbered dark spare is powered on the next edge. Its clock turns on exactly wake_dly + 1 cycles after its power does. Only then is the hand-over requested.
- R6: The hand-over request holds until migration-done is seen. On the next edge the spare becomes a working core with its no-new-work bit low. The drained core keeps power, loses its clock, and both one-hot request outputs clear.
- R7: A drained core is not eligible as a spare while its temperature is at or above steady-state. It becomes a warm spare on the first edge with its temperature below steady-state.
- R8: While a working core is at or above the effective level and no warm or dark spare is free, its throttle bit is high.
- R9: When several working cores are in crisis together, the lowest-numbered one is served first. The next one is served after the first hand-over completes.
- R10: Migration-done while no hand-over is in progress changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | NCORE*TW | Core temperatures, core i in bits [i*TW +: TW], unsigned |
| t_ss_i | input | TW | Steady-state temperature |
| t_act_i | input | TW | Programmed activation level |
| t_thr_i | input | TW | Throttling temperature |
| wake_dly_i | input | DW | Extra wait cycles between power and clock for a dark spare |
| mig_done_i | input | 1 | Migration of the requested threads is complete |
| no_new_o | output | NCORE | Per core: give this core no new work |
| pwr_en_o | output | NCORE | Per core power enable |
| clk_en_o | output | NCORE | Per core clock enable |
| mig_src_o | output | NCORE | One-hot core whose threads are to be moved |
| mig_dst_o | output | NCORE | One-hot core that receives the threads |
| throttle_o | output | NCORE | Per core throttle request, no spare free |

## Verification
Some properties are checked on every cycle. The source and destination requests are always one-hot and always rise and fall together. A core is never named as source unless its no-new-work bit is set. A core's clock never starts on a cycle in which it had no power. The wake countdown steps down by one each cycle, and migration-done during a hand-over returns the controller to idle. The clamped activation level also stays inside its window.

Other behaviour only the bench scenarios can show. These include the exact edge of a threshold crossing and the choice between warm and dark spares. They also include the measured power-to-clock spacing for several wake delays, the drained core rejoining only after it cools, and the throttle request when the pool is empty.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  typedef enum logic [2:0] {
    CS_ACTIVE,
    CS_HOT,
    CS_COLD,
    CS_WAKE,
    CS_JOIN,
    CS_DRAIN,
    CS_COOL
  } core_state_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_WAKE,
    CT_MIGR
  } ctl_state_e;

endpackage

// File: rtl/tsm_thresh.sv
module tsm_thresh #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] t_ss_i,
  input  logic [TW-1:0] t_act_i,
  input  logic [TW-1:0] t_thr_i,
  output logic [TW-1:0] act_eff_o
);

  // keep the activation level strictly inside (steady-state, throttle)
  always_comb begin
    if (t_act_i <= t_ss_i) begin
      act_eff_o = t_ss_i + 1'b1;
    end else if (t_act_i >= t_thr_i) begin
      act_eff_o = t_thr_i - 1'b1;
    end else begin
      act_eff_o = t_act_i;
    end
  end

endmodule

// File: rtl/tsm_pick.sv
module tsm_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);

  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
    any_o = taken;
  end

endmodule

// File: rtl/tsm_wake_timer.sv
module tsm_wake_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic          done_o
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

  AST_WAKE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/thermal_spare_mgr.sv
module thermal_spare_mgr
  import tsm_pkg::*;
#(
  parameter int          NCORE     = 4,
  parameter int          TW        = 8,
  parameter int          DW        = 8,
  parameter logic [NCORE-1:0] HOT_MASK  = 4'b0100,
  parameter logic [NCORE-1:0] COLD_MASK = 4'b1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE*TW-1:0] temp_i,
  input  logic [TW-1:0]       t_ss_i,
  input  logic [TW-1:0]       t_act_i,
  input  logic [TW-1:0]       t_thr_i,
  input  logic [DW-1:0]       wake_dly_i,
  input  logic                mig_done_i,
  output logic [NCORE-1:0]    no_new_o,
  output logic [NCORE-1:0]    pwr_en_o,
  output logic [NCORE-1:0]    clk_en_o,
  output logic [NCORE-1:0]    mig_src_o,
  output logic [NCORE-1:0]    mig_dst_o,
  output logic [NCORE-1:0]    throttle_o
);

  core_state_e     st_q [NCORE];
  core_state_e     st_d [NCORE];
  ctl_state_e      ctl_q, ctl_d;
  logic [NCORE-1:0] flag_q, flag_d;
  logic [TW-1:0]   tmp [NCORE];
  logic [TW-1:0]   act_eff;

  logic [NCORE-1:0] crisis, is_hot, is_cold;
  logic [NCORE-1:0] src_g, hot_g, cold_g;
  logic             src_any, hot_any, cold_any;
  logic             start, wake_load, wake_done;

  genvar g;
  generate
    for (g = 0; g < NCORE; g++) begin : g_core
      assign tmp[g]     = temp_i[g*TW +: TW];
      assign crisis[g]  = (st_q[g] == CS_ACTIVE) && (tmp[g] >= act_eff);
      assign is_hot[g]  = (st_q[g] == CS_HOT);
      assign is_cold[g] = (st_q[g] == CS_COLD);

      assign no_new_o[g]   = (st_q[g] != CS_ACTIVE) || flag_q[g];
      assign pwr_en_o[g]   = (st_q[g] != CS_COLD);
      assign clk_en_o[g]   = (st_q[g] == CS_ACTIVE) || (st_q[g] == CS_JOIN) ||
                             (st_q[g] == CS_DRAIN);
      assign mig_src_o[g]  = (ctl_q == CT_MIGR) && (st_q[g] == CS_DRAIN);
      assign mig_dst_o[g]  = (ctl_q == CT_MIGR) && (st_q[g] == CS_JOIN);
      assign throttle_o[g] = crisis[g] && !hot_any && !cold_any;

      // sticky over-threshold flag of a working core
      always_comb begin
        if (crisis[g]) begin
          flag_d[g] = 1'b1;
        end else if ((st_q[g] != CS_ACTIVE) || (tmp[g] < t_ss_i)) begin
          flag_d[g] = 1'b0;
        end else begin
          flag_d[g] = flag_q[g];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          if (HOT_MASK[g]) begin
            st_q[g] <= CS_HOT;
          end else if (COLD_MASK[g]) begin
            st_q[g] <= CS_COLD;
          end else begin
            st_q[g] <= CS_ACTIVE;
          end
          flag_q[g] <= 1'b0;
        end else begin
          st_q[g]   <= st_d[g];
          flag_q[g] <= flag_d[g];
        end
      end

      AST_PWR_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o[g]) |-> $past(pwr_en_o[g])); // R5
    end
  endgenerate

  tsm_thresh #(.TW(TW)) u_thresh (
    .t_ss_i   (t_ss_i),
    .t_act_i  (t_act_i),
    .t_thr_i  (t_thr_i),
    .act_eff_o(act_eff)
  );

  tsm_pick #(.N(NCORE)) u_pick_src (.req_i(crisis),  .gnt_o(src_g),  .any_o(src_any));
  tsm_pick #(.N(NCORE)) u_pick_hot (.req_i(is_hot),  .gnt_o(hot_g),  .any_o(hot_any));
  tsm_pick #(.N(NCORE)) u_pick_cld (.req_i(is_cold), .gnt_o(cold_g), .any_o(cold_any));

  assign start     = (ctl_q == CT_IDLE) && src_any && (hot_any || cold_any);
  assign wake_load = start && !hot_any;

  tsm_wake_timer #(.DW(DW)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wake_load),
    .load_val_i(wake_dly_i),
    .done_o    (wake_done)
  );

  // next-state for controller and per-core states
  always_comb begin
    ctl_d = ctl_q;
    for (int i = 0; i < NCORE; i++) begin
      st_d[i] = st_q[i];
      if ((st_q[i] == CS_COOL) && (tmp[i] < t_ss_i)) begin
        st_d[i] = CS_HOT;
      end
    end
    case (ctl_q)
      CT_IDLE: begin
        if (start) begin
          ctl_d = hot_any ? CT_MIGR : CT_WAKE;
          for (int i = 0; i < NCORE; i++) begin
            if (src_g[i]) st_d[i] = CS_DRAIN;
            if (hot_any && hot_g[i]) st_d[i] = CS_JOIN;
            if (!hot_any && cold_g[i]) st_d[i] = CS_WAKE;
          end
        end
      end
      CT_WAKE: begin
        if (wake_done) begin
          ctl_d = CT_MIGR;
          for (int i = 0; i < NCORE; i++) begin
            if (st_q[i] == CS_WAKE) st_d[i] = CS_JOIN;
          end
        end
      end
      CT_MIGR: begin
        if (mig_done_i) begin
          ctl_d = CT_IDLE;
          for (int i = 0; i < NCORE; i++) begin
            if (st_q[i] == CS_DRAIN) st_d[i] = CS_COOL;
            if (st_q[i] == CS_JOIN)  st_d[i] = CS_ACTIVE;
          end
        end
      end
      default: ctl_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CT_IDLE;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  AST_SRC_DST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mig_src_o) == (|mig_dst_o)) && $onehot0(mig_src_o) && $onehot0(mig_dst_o)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q == CT_MIGR) && mig_done_i) |=> ((ctl_q == CT_IDLE) && (mig_src_o == '0))); // R6
  AST_SRC_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mig_src_o & ~no_new_o) == '0)); // R3
  AST_ACT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, t_thr_i} > {1'b0, t_ss_i} + 2'd1) |-> ((act_eff > t_ss_i) && (act_eff < t_thr_i))); // R2

endmodule

// File: tb/sim_thermal_spare_mgr.sv
`timescale 1ns/1ps
module sim_thermal_spare_mgr;

  localparam int NCORE = 4;
  localparam int TW    = 8;
  localparam int DW    = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NCORE*TW-1:0] temp_i;
  logic [TW-1:0]       t_ss_i, t_act_i, t_thr_i;
  logic [DW-1:0]       wake_dly_i;
  logic                mig_done_i;
  logic [NCORE-1:0]    no_new_o, pwr_en_o, clk_en_o, mig_src_o, mig_dst_o, throttle_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  thermal_spare_mgr #(.NCORE(NCORE), .TW(TW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .t_ss_i(t_ss_i), .t_act_i(t_act_i),
    .t_thr_i(t_thr_i), .wake_dly_i(wake_dly_i), .mig_done_i(mig_done_i),
    .no_new_o(no_new_o), .pwr_en_o(pwr_en_o), .clk_en_o(clk_en_o),
    .mig_src_o(mig_src_o), .mig_dst_o(mig_dst_o), .throttle_o(throttle_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_temp(input int core, input int t);
    temp_i[core*TW +: TW] = t[TW-1:0];
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    mig_done_i = 1'b0;
    for (int i = 0; i < NCORE; i++) set_temp(i, 50);
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_done();
    mig_done_i = 1'b1;
    tick(1);
    mig_done_i = 1'b0;
  endtask

  // wait for a core clock to start, returns cycles waited
  task automatic wait_clk(input int core, output int n);
    n = 0;
    while (!clk_en_o[core] && n < 100) begin
      tick(1);
      n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int eff;
    int act_list [7] = '{60, 80, 81, 100, 119, 120, 150};
    t_ss_i = 8'd80; t_act_i = 8'd100; t_thr_i = 8'd120; wake_dly_i = 8'd3;
    temp_i = '0;
    do_reset();

    // R1 reset state
    chk("R1 no_new", no_new_o, 4'b1100);
    chk("R1 pwr", pwr_en_o, 4'b0111);
    chk("R1 clk", clk_en_o, 4'b0011);
    chk("R1 mig", {mig_src_o, mig_dst_o}, 8'h00);
    chk("R1 throttle", throttle_o, 4'b0000);

    // R10 stray done
    pulse_done();
    tick(1);
    chk("R10 clk", clk_en_o, 4'b0011);
    chk("R10 pwr", pwr_en_o, 4'b0111);
    chk("R10 no_new", no_new_o, 4'b1100);
    chk("R10 mig", {mig_src_o, mig_dst_o}, 8'h00);

    // R2 / R3 threshold sweep with clamping
    foreach (act_list[k]) begin
      do_reset();
      t_act_i = act_list[k][TW-1:0];
      if (act_list[k] <= 80) eff = 81;
      else if (act_list[k] >= 120) eff = 119;
      else eff = act_list[k];
      set_temp(0, eff - 1);
      tick(3);
      chk("R3 below level no_new", no_new_o[0], 1'b0);
      chk("R2 below level no hand-over", mig_src_o, 4'b0000);
      set_temp(0, eff);
      tick(1);
      chk("R2 at level hand-over", mig_src_o, 4'b0001);
      chk("R3 at level no_new", no_new_o[0], 1'b1);
    end

    // R4 / R6 warm spare hand-over
    t_act_i = 8'd100;
    do_reset();
    set_temp(0, 100);
    tick(1);
    chk("R4 src", mig_src_o, 4'b0001);
    chk("R4 dst", mig_dst_o, 4'b0100);
    chk("R4 clk", clk_en_o, 4'b0111);
    tick(5);
    chk("R6 held", {mig_src_o, mig_dst_o}, 8'h14);
    pulse_done();
    chk("R6 clk", clk_en_o, 4'b0110);
    chk("R6 pwr", pwr_en_o, 4'b0111);
    chk("R6 no_new", no_new_o, 4'b1001);
    chk("R6 mig clear", {mig_src_o, mig_dst_o}, 8'h00);

    // R5 dark spare, drained core 0 still hot so not eligible (R7)
    set_temp(1, 100);
    tick(1);
    chk("R5 power first", pwr_en_o, 4'b1111);
    chk("R5 clock off", clk_en_o[3], 1'b0);
    chk("R5 no request yet", mig_src_o, 4'b0000);
    wait_clk(3, n);
    chk("R5 wake spacing", n, 4);
    chk("R5 src", mig_src_o, 4'b0010);
    chk("R5 dst", mig_dst_o, 4'b1000);
    pulse_done();
    chk("R6 second clk", clk_en_o, 4'b1100);
    chk("R6 second no_new", no_new_o, 4'b0011);

    // R8 empty pool
    set_temp(2, 110);
    tick(1);
    chk("R8 throttle", throttle_o, 4'b0100);
    chk("R8 no hand-over", mig_src_o, 4'b0000);
    chk("R3 flag on throttled core", no_new_o, 4'b0111);

    // R7 drained core at steady-state is not yet a spare
    set_temp(0, 80);
    tick(3);
    chk("R7 not eligible", throttle_o, 4'b0100);
    chk("R7 still gated", clk_en_o[0], 1'b0);
    set_temp(0, 79);
    tick(2);
    chk("R7 rejoined src", mig_src_o, 4'b0100);
    chk("R7 rejoined dst", mig_dst_o, 4'b0001);
    chk("R7 throttle off", throttle_o, 4'b0000);

    // R9 simultaneous crises, also zero wake delay
    wake_dly_i = 8'd0;
    do_reset();
    set_temp(0, 100);
    set_temp(1, 100);
    tick(1);
    chk("R9 lowest first", mig_src_o, 4'b0001);
    chk("R9 dark spare left", throttle_o, 4'b0000);
    pulse_done();
    chk("R9 idle between", mig_src_o, 4'b0000);
    tick(1);
    chk("R9 second powered", pwr_en_o[3], 1'b1);
    wait_clk(3, n);
    chk("R5 zero delay spacing", n, 1);
    chk("R9 second src", mig_src_o, 4'b0010);
    chk("R9 second dst", mig_dst_o, 4'b1000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule